// File: doc/BRIEF.md
# Receive frame status tracker

This block sits between the receive side of a serial infrared-style link and a host register port. Received bytes enter a small FIFO together with a start-of-frame and an end-of-frame marker. The host, or a DMA engine acting for it, drains the FIFO one entry per read of the data register.

When the entry carrying the end-of-frame marker is read out, the block captures a frame record in a holding register. The record holds the number of entries read for that frame and an error flag for the frame. At the same moment the block raises a frame-done status bit.

Two further status bits report frame-level loss rather than plain FIFO conditions:
- Record lost: a new frame finished before the host had read the previous record.
- Frame lost: a receiver overrun arrived at a frame boundary, so no entry could carry the error, and the whole incoming frame is discarded.

An overrun in the middle of a frame instead marks the newest FIFO entry, so the loss is reported with that frame's record.

Top module: `rx_frame_status`

## Requirements
- R1: After reset the status register reads 0 and the frame record reads 0. A read of the data register on the empty FIFO returns 0 and changes nothing.
- R2: The data register returns entries in push order. Its format is bits [7:0] the byte, bit 8 the end-of-frame marker, bit 9 the entry error flag, and all other bits 0. Each read of a non-empty FIFO removes one entry.
- R3: Reading the entry that carries end-of-frame sets status bit 0 (done). The same read loads the frame record: bits [11:0] hold the number of entries read for that frame including the last one, modulo 4096, and bit 16 holds the OR of those entries' error flags. The per-frame count then restarts at 0.
- R4: Reading the frame record (address 2) clears status bit 0 and leaves the record unchanged.
- R5: Reading an end-of-frame entry while status bit 0 is already set sets status bit 1 (record lost), and the record is overwritten with the new frame.
- R6: An overrun pulse when the FIFO is empty, or when its newest entry carries end-of-frame, sets status bit 2 (frame lost). After that, pushes are discarded until a push with the start-of-frame marker, which is accepted.
- R7: An overrun pulse when the newest entry lacks end-of-frame sets that entry's error flag and does not set status bit 2.
- R8: A write to the status register (address 1) with write bit 0 set clears status bit 1, and with write bit 1 set clears status bit 2. A written 0 has no effect, and bit 0 cannot be written. A set event in the same cycle as a clear leaves the bit set.
- R9: A push while the FIFO holds DEPTH entries is discarded, and the stored entries are unchanged.
- R10: Reserved bits of every register read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receiver pushes one byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | Byte is the last of its frame |
| rx_sof | input | 1 | Byte is the first of its frame |
| rx_ovr | input | 1 | Receiver overrun pulse |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 data, 1 status, 2 frame record, 3 unmapped |
| bus_wdata | input | 2 | Clear mask: bit 0 record lost, bit 1 frame lost |
| bus_rdata | output | 32 | Read data, combinational from current state |

## Verification
The bench sweeps every frame length from one entry up to a full FIFO and checks each read-out word and the captured count. A counter that is off by one, or that fails to restart, would show up at once.

It finishes two frames without reading the record, to catch a design that does not flag the lost record or that keeps the stale count. It also fires an overrun in three positions: mid-frame, behind a completed frame, and into an empty FIFO. A design that confuses these would mark the wrong entry, miss the frame loss, or keep accepting bytes of a discarded frame.

Finally, it clears a status bit in the same cycle as a new loss event, so that clear-wins priority would leave the bit wrongly at 0.

// File: rtl/rxfs_pkg.sv
// Shared types for the receive frame status tracker.
package rxfs_pkg;
    // One FIFO entry: flags above the byte.
    typedef struct packed {
        logic       err;
        logic       eof;
        logic [7:0] data;
    } rxfs_entry_t;

    // Register addresses seen by the host.
    typedef enum logic [1:0] {
        ADR_DATA = 2'd0,
        ADR_STAT = 2'd1,
        ADR_INFO = 2'd2,
        ADR_NONE = 2'd3
    } rxfs_addr_e;
endpackage

// File: rtl/rxfs_ingress.sv
// Ingress filter: decides which received bytes enter the FIFO and classifies
// overrun pulses. Assumes an overrun and a push do not share a cycle.
module rxfs_ingress (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_eof,
    input  logic rx_sof,
    input  logic rx_ovr,
    input  logic fifo_full,
    input  logic fifo_empty,
    input  logic newest_eof,
    output logic fifo_push,
    output logic fifo_mark,
    output logic lost_evt
);
    logic drop_q;
    logic boundary;

    // Overrun at a frame boundary has no entry to carry it.
    assign boundary  = fifo_empty || newest_eof;
    assign lost_evt  = rx_ovr && boundary;
    assign fifo_mark = rx_ovr && !boundary;

    // Accept a byte when space exists and the frame is not being discarded.
    assign fifo_push = rx_valid && !fifo_full && (!drop_q || rx_sof);

    // Discard state: entered on a lost frame, left at the next start of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (lost_evt) begin
            drop_q <= 1'b1;
        end else if (rx_valid && rx_sof) begin
            drop_q <= 1'b0;
        end
    end

    // Unused marker kept for symmetry of the push interface.
    logic unused_eof;
    assign unused_eof = rx_eof;
endmodule

// File: rtl/rxfs_fifo.sv
// Receive FIFO of DEPTH entries. Supports marking the newest entry with an
// error flag. Assumes the caller never pushes when full or pops when empty.
module rxfs_fifo
    import rxfs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  rxfs_entry_t push_entry,
    input  logic        pop,
    input  logic        mark,
    output rxfs_entry_t head,
    output logic        full,
    output logic        empty,
    output logic        newest_eof
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    rxfs_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] new_ptr;
    logic [LVL_W-1:0] level;

    assign full       = (level == FULL_LVL);
    assign empty      = (level == '0);
    assign new_ptr    = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
    assign head       = mem[rd_ptr];
    assign newest_eof = !empty && mem[new_ptr].eof;

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    // Entry storage: write on push, flag the newest entry on mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (mark && !empty) mem[new_ptr].err <= 1'b1;
            if (push) mem[wr_ptr] <= push_entry;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R1
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rxfs_regs.sv
// Host register file: pops the FIFO on data reads, counts entries per frame,
// captures the frame record and keeps the three status bits.
module rxfs_regs
    import rxfs_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int BUS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [1:0]        bus_wdata,
    input  rxfs_entry_t       head,
    input  logic              fifo_empty,
    input  logic              lost_evt,
    output logic              pop,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam int ERR_POS = 16;

    logic [CNT_W-1:0] byte_cnt;
    logic             acc_err;
    logic [CNT_W-1:0] info_cnt;
    logic             info_err;
    logic             st_done;
    logic             st_ilost;
    logic             st_flost;
    logic             last_pop;
    logic             info_rd;
    logic             stat_wr;

    assign pop      = bus_rd && (bus_addr == ADR_DATA) && !fifo_empty;
    assign last_pop = pop && head.eof;
    assign info_rd  = bus_rd && (bus_addr == ADR_INFO);
    assign stat_wr  = bus_wr && (bus_addr == ADR_STAT);

    // Running count and error OR for the frame being read out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            acc_err  <= 1'b0;
        end else if (pop) begin
            byte_cnt <= last_pop ? '0 : byte_cnt + 1'b1;
            acc_err  <= last_pop ? 1'b0 : (acc_err || head.err);
        end
    end

    // Frame record capture on the last entry of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_cnt <= '0;
            info_err <= 1'b0;
        end else if (last_pop) begin
            info_cnt <= byte_cnt + 1'b1;
            info_err <= acc_err || head.err;
        end
    end

    // Status bits: set events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done  <= 1'b0;
            st_ilost <= 1'b0;
            st_flost <= 1'b0;
        end else begin
            if (last_pop)     st_done <= 1'b1;
            else if (info_rd) st_done <= 1'b0;
            if (last_pop && st_done)          st_ilost <= 1'b1;
            else if (stat_wr && bus_wdata[0]) st_ilost <= 1'b0;
            if (lost_evt)                     st_flost <= 1'b1;
            else if (stat_wr && bus_wdata[1]) st_flost <= 1'b0;
        end
    end

    // Read mux; reserved bits and the unmapped address return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_DATA: if (!fifo_empty) bus_rdata[9:0] = head;
            ADR_STAT: bus_rdata[2:0] = {st_flost, st_ilost, st_done};
            ADR_INFO: begin
                bus_rdata[CNT_W-1:0] = info_cnt;
                bus_rdata[ERR_POS]   = info_err;
            end
            default:  bus_rdata = '0;
        endcase
    end

    // R3
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_pop |=> st_done);
    // R5
    ilost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pop && st_done) |=> st_ilost);
    // R6
    flost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_evt |=> st_flost);
    // R8
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !bus_wdata[1] && st_flost) |=> st_flost);
endmodule

// File: rtl/rx_frame_status.sv
// Top of the receive frame status tracker: ingress filter, FIFO and register
// file. Assumes one register access per cycle from the host.
module rx_frame_status
    import rxfs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_eof,
    input  logic        rx_sof,
    input  logic        rx_ovr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [1:0]  bus_wdata,
    output logic [31:0] bus_rdata
);
    logic        fifo_push;
    logic        fifo_mark;
    logic        fifo_pop;
    logic        fifo_full;
    logic        fifo_empty;
    logic        newest_eof;
    logic        lost_evt;
    rxfs_entry_t head;
    rxfs_entry_t in_entry;

    assign in_entry = '{err: 1'b0, eof: rx_eof, data: rx_byte};

    rxfs_ingress u_ingress (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_eof     (rx_eof),
        .rx_sof     (rx_sof),
        .rx_ovr     (rx_ovr),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .newest_eof (newest_eof),
        .fifo_push  (fifo_push),
        .fifo_mark  (fifo_mark),
        .lost_evt   (lost_evt)
    );

    rxfs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (fifo_push),
        .push_entry (in_entry),
        .pop        (fifo_pop),
        .mark       (fifo_mark),
        .head       (head),
        .full       (fifo_full),
        .empty      (fifo_empty),
        .newest_eof (newest_eof)
    );

    rxfs_regs #(.CNT_W(CNT_W), .BUS_W(32)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .head       (head),
        .fifo_empty (fifo_empty),
        .lost_evt   (lost_evt),
        .pop        (fifo_pop),
        .bus_rdata  (bus_rdata)
    );
endmodule

// File: tb/tb_rx_frame_status.sv
module tb_rx_frame_status;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_eof = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_ovr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [1:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rx_frame_status #(.DEPTH(DEPTH), .CNT_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_eof(rx_eof), .rx_sof(rx_sof), .rx_ovr(rx_ovr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FIL%s %s: actual %h expected %h", "", req, act, exp);
        end
    endtask

    task automatic idle();
        rx_valid = 0; rx_ovr = 0; bus_rd = 0; bus_wr = 0;
        rx_eof = 0; rx_sof = 0; bus_wdata = '0;
    endtask

    task automatic push(logic [7:0] b, logic eof, logic sof);
        @(negedge clk);
        rx_valid = 1; rx_byte = b; rx_eof = eof; rx_sof = sof;
        @(posedge clk); #1 idle();
    endtask

    task automatic overrun(logic with_clr);
        @(negedge clk);
        rx_ovr = 1;
        if (with_clr) begin bus_wr = 1; bus_addr = 2'd1; bus_wdata = 2'b10; end
        @(posedge clk); #1 idle();
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1 idle();
    endtask

    task automatic wr(logic [1:0] a, logic [1:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 idle();
    endtask

    function automatic logic [31:0] word(logic [7:0] b, logic eof, logic err);
        return {22'd0, err, eof, b};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        rd(2'd1, v); check("R1 status", v, 32'd0);
        rd(2'd2, v); check("R1 record", v, 32'd0);
        rd(2'd0, v); check("R1 empty data", v, 32'd0);
        rd(2'd1, v); check("R1 status after empty read", v, 32'd0);
        // R10: unmapped address
        rd(2'd3, v); check("R10 unmapped", v, 32'd0);

        // R2 R3 R4: sweep every frame length up to full depth
        for (int len = 1; len <= DEPTH; len++) begin
            for (int i = 0; i < len; i++)
                push(8'(len * 16 + i), i == len - 1, i == 0);
            for (int i = 0; i < len; i++) begin
                rd(2'd0, v);
                check("R2 order", v, word(8'(len * 16 + i), i == len - 1, 1'b0));
            end
            rd(2'd1, v); check("R3 done set", v, 32'd1);
            rd(2'd2, v); check("R3 record count", v, 32'(len));
            rd(2'd1, v); check("R4 done cleared", v, 32'd0);
            rd(2'd2, v); check("R4 record kept", v, 32'(len));
        end

        // R5: two frames, record not read between them
        push(8'h11, 0, 1); push(8'h12, 1, 0);
        rd(2'd0, v); rd(2'd0, v);
        push(8'h21, 0, 1); push(8'h22, 0, 0); push(8'h23, 1, 0);
        for (int i = 0; i < 3; i++) rd(2'd0, v);
        rd(2'd1, v); check("R5 record lost", v, 32'd3);
        rd(2'd2, v); check("R5 record overwritten", v, 32'd3);
        // R8: zero write and bit 0 not writable
        wr(2'd1, 2'b00);
        rd(2'd1, v); check("R8 zero write", v, 32'd2);
        wr(2'd1, 2'b01);
        rd(2'd1, v); check("R8 clear record lost", v, 32'd0);

        // R9: overfill
        for (int i = 0; i < DEPTH + 2; i++) push(8'(8'h40 + i), i == DEPTH - 1, i == 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(2'd0, v); check("R9 kept entries", v, word(8'(8'h40 + i), i == DEPTH - 1, 1'b0));
        end
        rd(2'd0, v); check("R9 extra dropped", v, 32'd0);
        rd(2'd2, v); check("R9 record", v, 32'(DEPTH));

        // R7: mid-frame overrun
        push(8'h51, 0, 1); push(8'h52, 0, 0);
        overrun(1'b0);
        push(8'h53, 1, 0);
        rd(2'd0, v); check("R7 first entry", v, word(8'h51, 0, 0));
        rd(2'd0, v); check("R7 marked entry", v, word(8'h52, 0, 1));
        rd(2'd0, v); check("R7 last entry", v, word(8'h53, 1, 0));
        rd(2'd1, v); check("R7 no frame lost", v, 32'd1);
        rd(2'd2, v); check("R7 record err", v, 32'h0001_0003);

        // R6: overrun behind a completed frame
        push(8'h61, 1, 1);
        overrun(1'b0);
        rd(2'd1, v); check("R6 frame lost", v, 32'd4);
        push(8'hA1, 0, 0); push(8'hA2, 1, 0);
        push(8'hB0, 1, 1);
        rd(2'd0, v); check("R6 older frame", v, word(8'h61, 1, 0));
        rd(2'd0, v); check("R6 resumed at sof", v, word(8'hB0, 1, 0));
        rd(2'd0, v); check("R6 discarded bytes", v, 32'd0);
        rd(2'd1, v); check("R6 status", v, 32'd7);
        wr(2'd1, 2'b11);
        rd(2'd1, v); check("R8 clear both", v, 32'd1);
        rd(2'd2, v); check("R6 record", v, 32'd1);

        // R8: set beats clear (overrun into empty FIFO, R6 empty case)
        overrun(1'b1);
        rd(2'd1, v); check("R8 set priority", v, 32'd4);
        wr(2'd1, 2'b10);
        rd(2'd1, v); check("R8 frame lost cleared", v, 32'd0);
        push(8'hC1, 1, 0);
        rd(2'd0, v); check("R6 empty overrun drop", v, 32'd0);
        push(8'hC2, 1, 1);
        rd(2'd0, v); check("R6 sof accepted", v, word(8'hC2, 1, 0));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule